// File: doc/BRIEF.md
# Two-wire serial programming command interface

This block is the target side of a two-wire programming link: one clock line and one data line that is shared in both directions. It works in a fast system clock domain. Both pins pass through synchronisers, and the block detects clock edges there. A host clocks in a 6-bit command, least significant bit first, with each bit taken on a falling clock edge. Some commands carry a 16-clock data frame: a start slot, 14 data bits sent least significant bit first, and a stop slot. For a load, the block collects the word from the pin. For a read, the block turns the pin around partway through the frame and drives a word back.

The block decodes every command into a one-cycle strobe that carries a kind code. A load strobe also carries the assembled 14-bit word. Memory-side logic answers a read strobe by presenting a word, and the block serialises that word. Two protection inputs force read data to zero. The data-memory variants carry only 8 meaningful bits, but the frame is still 16 clocks long. When the mode-entry input is low, framing is held at a command boundary. An optional idle timeout also returns framing to a command boundary.

Top module: `sprog_target`

## Requirements
- R1: After reset, and during any cycle that follows a cycle with `link_en_i` low, `sdat_oe_o` is 0 and `cmd_stb_o` is 0.
- R2: A command is the 6 bits on the data pin at 6 successive falling clock edges, first bit = bit 0. The codes and their `cmd_kind_o` values are listed here. An x is a don't-care bit.
  - xx0000 gives 1 (load config).
  - xx0010 gives 2 (load program).
  - xx0011 gives 3 (load data memory).
  - xx0100 gives 4 (read program).
  - xx0101 gives 5 (read data memory).
  - xx0110 gives 6 (increment).
  - x01000 gives 7 (begin, internally timed).
  - x11000 gives 8 (begin, externally timed).
  - x01010 gives 9 (end programming).
  - xx1001 gives 10 (bulk erase program).
  - xx1011 gives 11 (bulk erase data).
  - x10001 gives 12 (row erase).
- R3: A command with no data frame (kinds 6 to 12) strobes once after its 6th falling edge. The very next clock is bit 0 of a new command.
- R4: Any 6-bit code not listed in R2 produces no strobe. The next clock starts a new command.
- R5: After kinds 1 to 3, a 16-clock frame follows. Data bits 0 to 13 are taken at falling edges 2 to 15 of the frame. After the 16th falling edge, one strobe carries the kind and `ld_word_o`.
- R6: For kind 3, `ld_word_o[7:0]` holds the first 8 data bits and `ld_word_o[13:8]` is 0, whatever the host sent in those slots.
- R7: Kinds 4 and 5 strobe after the 6th command falling edge. `rd_word_i` is sampled at the 2nd rising edge of the frame. At that edge `sdat_oe_o` rises and `sdat_o` shows bit 0. Each later rising edge advances one bit. `sdat_oe_o` falls at the 16th rising edge.
- R8: For kind 5, only `rd_word_i[7:0]` is sent, and the remaining 6 data slots are driven 0.
- R9: With `prot_prog_i` high, kind 4 sends all zeros. With `prot_data_i` high, kind 5 sends all zeros. Neither flag affects the other kind.
- R10: Driving `link_en_i` low for at least one cycle discards a partly received command or frame. Framing restarts at bit 0 of a command.
- R11: When framing is mid-command or mid-frame and `IDLE_LIMIT` (nonzero) system cycles pass with no clock edge, framing returns to bit 0 of a command and the output enable drops.
- R12: `cmd_stb_o` is a single-cycle pulse and is never high while `sdat_oe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en_i | input | 1 | Mode-entry level; low holds framing at a command boundary |
| sclk_i | input | 1 | Asynchronous link clock pin |
| sdat_i | input | 1 | Asynchronous data pin, input side |
| sdat_o | output | 1 | Data pin, output side |
| sdat_oe_o | output | 1 | Data pin output enable |
| prot_prog_i | input | 1 | Program read protection, forces zeros |
| prot_data_i | input | 1 | Data-memory read protection, forces zeros |
| rd_word_i | input | 14 | Word to send for a read command |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 4 | Kind code of the strobed command (R2) |
| ld_word_o | output | 14 | Assembled load word, valid with load strobes |

## Verification
The hardest cases to reach are framing slips: a command that is broken off part way, either by a drop of the mode-entry level or by a host that stalls. In both cases the bits received so far must be discarded rather than shifted into the next command. The bench sends the first few bits of a command, then either pulses the mode-entry input low or idles longer than the timeout. It then sends a complete command, and any bit left over from the broken one would show up as a wrong kind. The read turnaround is checked by sampling the output enable and the pin after every rising edge of the frame. This confirms that the enable appears at the second rising edge and is gone after the sixteenth.

// File: rtl/plink_pkg.sv
package plink_pkg;

    localparam int CMD_BITS   = 6;
    localparam int WORD_BITS  = 14;
    localparam int DMEM_BITS  = 8;
    localparam int FRAME_CLKS = WORD_BITS + 2;
    localparam int KIND_BITS  = 4;

    typedef enum logic [KIND_BITS-1:0] {
        K_NONE  = 4'd0,
        K_LDCFG = 4'd1,
        K_LDPRG = 4'd2,
        K_LDDAT = 4'd3,
        K_RDPRG = 4'd4,
        K_RDDAT = 4'd5,
        K_INC   = 4'd6,
        K_BEGI  = 4'd7,
        K_BEGE  = 4'd8,
        K_ENDP  = 4'd9,
        K_ERPRG = 4'd10,
        K_ERDAT = 4'd11,
        K_ERROW = 4'd12
    } cmd_kind_e;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // one system-cycle view of the synchronised pins
    typedef struct packed {
        logic rise;
        logic fall;
        logic dat;
    } pin_ev_t;

    function automatic cmd_kind_e decode_cmd(input logic [CMD_BITS-1:0] c);
        cmd_kind_e k;
        casez (c)
            6'b??0000: k = K_LDCFG;
            6'b??0010: k = K_LDPRG;
            6'b??0011: k = K_LDDAT;
            6'b??0100: k = K_RDPRG;
            6'b??0101: k = K_RDDAT;
            6'b??0110: k = K_INC;
            6'b?01000: k = K_BEGI;
            6'b?11000: k = K_BEGE;
            6'b?01010: k = K_ENDP;
            6'b??1001: k = K_ERPRG;
            6'b??1011: k = K_ERDAT;
            6'b?10001: k = K_ERROW;
            default:   k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_load(input cmd_kind_e k);
        return (k == K_LDCFG) || (k == K_LDPRG) || (k == K_LDDAT);
    endfunction

    function automatic logic is_read(input cmd_kind_e k);
        return (k == K_RDPRG) || (k == K_RDDAT);
    endfunction

    function automatic logic has_frame(input cmd_kind_e k);
        return is_load(k) || is_read(k);
    endfunction

endpackage

// File: rtl/plink_sync.sv
module plink_sync
    import plink_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_i,
    input  logic    sdat_i,
    output pin_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] ck_ff;
    logic [STAGES-1:0] dt_ff;
    logic              ck_last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_ff <= '0;
                    dt_ff <= '0;
                end else begin
                    ck_ff <= sclk_i;
                    dt_ff <= sdat_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_ff <= '0;
                    dt_ff <= '0;
                end else begin
                    ck_ff <= {ck_ff[STAGES-2:0], sclk_i};
                    dt_ff <= {dt_ff[STAGES-2:0], sdat_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ck_last <= 1'b0;
        else     ck_last <= ck_ff[TOP];
    end

    always_comb begin
        ev.rise = ck_ff[TOP] & ~ck_last;
        ev.fall = ~ck_ff[TOP] & ck_last;
        ev.dat  = dt_ff[TOP];
    end
endmodule

// File: rtl/plink_idle.sv
module plink_idle #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic pin_edge,
    output logic abort
);
    generate
        if (LIMIT == 0) begin : g_off
            assign abort = 1'b0;
        end else begin : g_on
            localparam int IW = $clog2(LIMIT + 1);
            localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);
            logic [IW-1:0] idle_cnt;

            always_ff @(posedge clk) begin
                if (rst || !busy || pin_edge) idle_cnt <= '0;
                else if (idle_cnt != LAST)    idle_cnt <= idle_cnt + 1'b1;
            end

            assign abort = busy && !pin_edge && (idle_cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/plink_frame.sv
module plink_frame
    import plink_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_en,
    input  logic                 abort,
    input  pin_ev_t              ev,
    input  logic                 prot_prog,
    input  logic                 prot_data,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic                 busy,
    output logic                 cmd_stb,
    output cmd_kind_e            cmd_kind,
    output logic [WORD_BITS-1:0] ld_word,
    output logic                 sdat,
    output logic                 sdat_oe
);
    localparam int CW = $clog2(FRAME_CLKS);
    localparam logic [CW-1:0] CMD_LAST = CW'(CMD_BITS - 1);
    localparam logic [CW-1:0] FRM_LAST = CW'(FRAME_CLKS - 1);
    localparam logic [CW-1:0] FIRST_D  = CW'(1);
    localparam logic [CW-1:0] LAST_D   = CW'(WORD_BITS);
    localparam int PAD = WORD_BITS - DMEM_BITS;

    phase_e                phase;
    logic [CW-1:0]         cnt;
    logic [CMD_BITS-1:0]   cmd_sh;
    logic [CMD_BITS-1:0]   cmd_next;
    cmd_kind_e             dec_kind;
    cmd_kind_e             cur_kind;
    logic [WORD_BITS-1:0]  ld_sh;
    logic [WORD_BITS-1:0]  out_sh;
    logic [WORD_BITS-1:0]  rd_masked;
    logic [WORD_BITS-1:0]  ld_final;

    always_comb begin
        cmd_next = {ev.dat, cmd_sh[CMD_BITS-1:1]};
        dec_kind = decode_cmd(cmd_next);
        busy     = (phase == PH_DATA) || (cnt != '0);
    end

    always_comb begin
        if (cur_kind == K_RDDAT)
            rd_masked = prot_data ? '0 : {{PAD{1'b0}}, rd_word[DMEM_BITS-1:0]};
        else
            rd_masked = prot_prog ? '0 : rd_word;
        if (cur_kind == K_LDDAT)
            ld_final = {{PAD{1'b0}}, ld_sh[DMEM_BITS-1:0]};
        else
            ld_final = ld_sh;
    end

    always_ff @(posedge clk) begin
        if (rst || !link_en || abort) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            cmd_sh   <= '0;
            cur_kind <= K_NONE;
            cmd_stb  <= 1'b0;
            sdat_oe  <= 1'b0;
            if (rst) begin
                cmd_kind <= K_NONE;
                ld_word  <= '0;
                ld_sh    <= '0;
                out_sh   <= '0;
            end
        end else begin
            cmd_stb <= 1'b0;
            if (ev.fall) begin
                if (phase == PH_CMD) begin
                    cmd_sh <= cmd_next;
                    if (cnt == CMD_LAST) begin
                        cnt      <= '0;
                        cur_kind <= dec_kind;
                        if (has_frame(dec_kind)) phase <= PH_DATA;
                        if (dec_kind != K_NONE && !is_load(dec_kind)) begin
                            cmd_stb  <= 1'b1;
                            cmd_kind <= dec_kind;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    if (cnt >= FIRST_D && cnt <= LAST_D)
                        ld_sh <= {ev.dat, ld_sh[WORD_BITS-1:1]};
                    if (cnt == FRM_LAST) begin
                        cnt   <= '0;
                        phase <= PH_CMD;
                        if (is_load(cur_kind)) begin
                            cmd_stb  <= 1'b1;
                            cmd_kind <= cur_kind;
                            ld_word  <= ld_final;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
            if (ev.rise && phase == PH_DATA && is_read(cur_kind)) begin
                if (cnt == FIRST_D) begin
                    out_sh  <= rd_masked;
                    sdat_oe <= 1'b1;
                end else if (cnt == FRM_LAST) begin
                    sdat_oe <= 1'b0;
                end else if (cnt > FIRST_D) begin
                    out_sh <= out_sh >> 1;
                end
            end
        end
    end

    assign sdat = sdat_oe & out_sh[0];
endmodule

// File: rtl/sprog_target.sv
module sprog_target
    import plink_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 4096
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_en_i,
    input  logic                 sclk_i,
    input  logic                 sdat_i,
    output logic                 sdat_o,
    output logic                 sdat_oe_o,
    input  logic                 prot_prog_i,
    input  logic                 prot_data_i,
    input  logic [WORD_BITS-1:0] rd_word_i,
    output logic                 cmd_stb_o,
    output logic [KIND_BITS-1:0] cmd_kind_o,
    output logic [WORD_BITS-1:0] ld_word_o
);
    pin_ev_t   ev;
    logic      busy;
    logic      abort;
    cmd_kind_e kind;

    plink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .sdat_i (sdat_i),
        .ev     (ev)
    );

    plink_idle #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .pin_edge (ev.rise | ev.fall),
        .abort    (abort)
    );

    plink_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .link_en   (link_en_i),
        .abort     (abort),
        .ev        (ev),
        .prot_prog (prot_prog_i),
        .prot_data (prot_data_i),
        .rd_word   (rd_word_i),
        .busy      (busy),
        .cmd_stb   (cmd_stb_o),
        .cmd_kind  (kind),
        .ld_word   (ld_word_o),
        .sdat      (sdat_o),
        .sdat_oe   (sdat_oe_o)
    );

    assign cmd_kind_o = kind;
endmodule

// File: rtl/plink_chk.sv
module plink_chk (
    input logic        clk,
    input logic        rst,
    input logic        link_en_i,
    input logic        sdat_oe_o,
    input logic        cmd_stb_o,
    input logic [3:0]  cmd_kind_o,
    input logic [13:0] ld_word_o
);
    // R1
    en_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !link_en_i |=> (!sdat_oe_o && !cmd_stb_o));

    // R12
    stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb_o |=> !cmd_stb_o);

    // R12
    stb_not_driving_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb_o |-> !sdat_oe_o);

    // R2
    kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb_o |-> (cmd_kind_o != 4'd0 && cmd_kind_o <= 4'd12));

    // R6
    dmem_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb_o && cmd_kind_o == 4'd3) |-> (ld_word_o[13:8] == 6'd0));
endmodule

bind sprog_target plink_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_en_i  (link_en_i),
    .sdat_oe_o  (sdat_oe_o),
    .cmd_stb_o  (cmd_stb_o),
    .cmd_kind_o (cmd_kind_o),
    .ld_word_o  (ld_word_o)
);

// File: tb/sim_sprog_target.sv
`timescale 1ns/1ps
module sim_sprog_target;
    localparam int HALF  = 8;
    localparam int LIMIT = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_en = 1'b0;
    logic        sclk_h = 1'b0;
    logic        sdat_h = 1'b0;
    logic        prot_prog = 1'b0;
    logic        prot_data = 1'b0;
    logic [13:0] rd_word = '0;
    logic        sdat_o, sdat_oe, cmd_stb;
    logic [3:0]  cmd_kind;
    logic [13:0] ld_word;
    logic        pin;

    int n_chk  = 0;
    int n_fail = 0;
    int n_stb  = 0;
    bit done   = 0;

    typedef struct { logic [3:0] kind; logic [13:0] word; logic has_word; string tag; } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    assign pin = sdat_oe ? sdat_o : sdat_h;

    sprog_target #(.SYNC_STAGES(2), .IDLE_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst(rst), .link_en_i(link_en), .sclk_i(sclk_h), .sdat_i(pin),
        .sdat_o(sdat_o), .sdat_oe_o(sdat_oe), .prot_prog_i(prot_prog),
        .prot_data_i(prot_data), .rd_word_i(rd_word), .cmd_stb_o(cmd_stb),
        .cmd_kind_o(cmd_kind), .ld_word_o(ld_word)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] k, input logic [13:0] w, input logic hw, input string tag);
        exp_t e;
        e.kind = k; e.word = w; e.has_word = hw; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares every strobe with the scoreboard head
    always @(negedge clk) begin
        if (!rst && cmd_stb) begin
            n_stb++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 unexpected strobe", {28'd0, cmd_kind}, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cmd_kind == e.kind, e.tag, {28'd0, cmd_kind}, {28'd0, e.kind});
                if (e.has_word)
                    check(ld_word == e.word, e.tag, {18'd0, ld_word}, {18'd0, e.word});
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        sdat_h = b;
        sclk_h = 1'b1;
        wait_clk(HALF);
        sclk_h = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) send_bit(c[i]);
    endtask

    task automatic send_load(input logic [13:0] w);
        send_bit(1'b0);
        for (int i = 0; i < 14; i++) send_bit(w[i]);
        send_bit(1'b0);
    endtask

    task automatic read_frame(input logic [13:0] expw, input string tag);
        logic [15:0] got_oe;
        logic [13:0] got_d;
        got_oe = '0;
        got_d  = '0;
        for (int k = 1; k <= 16; k++) begin
            sdat_h = 1'b0;
            sclk_h = 1'b1;
            wait_clk(HALF);
            got_oe[k-1] = sdat_oe;
            if (k >= 2 && k <= 15) got_d[k-2] = sdat_o;
            sclk_h = 1'b0;
            wait_clk(HALF);
        end
        check(got_oe == 16'h7FFE, {tag, " R7 enable window"}, {16'd0, got_oe}, 32'h7FFE);
        check(got_d == expw, {tag, " read data"}, {18'd0, got_d}, {18'd0, expw});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int stb_before;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R1: reset state and enable low
        check(sdat_oe == 1'b0 && cmd_stb == 1'b0, "R1 reset state", {30'd0, sdat_oe, cmd_stb}, 32'd0);
        send_cmd(6'b000110);
        wait_clk(4);
        check(n_stb == 0, "R1 no strobe while disabled", n_stb, 0);
        link_en = 1'b1;
        wait_clk(4);

        // R2 R3: dataless commands back to back, don't-care bits set
        push(4'd6,  '0, 0, "R3 increment");       send_cmd(6'b110110);
        push(4'd7,  '0, 0, "R2 begin internal");  send_cmd(6'b101000);
        push(4'd8,  '0, 0, "R2 begin external");  send_cmd(6'b111000);
        push(4'd9,  '0, 0, "R2 end programming"); send_cmd(6'b001010);
        push(4'd10, '0, 0, "R2 bulk erase prog"); send_cmd(6'b111001);
        push(4'd11, '0, 0, "R2 bulk erase data"); send_cmd(6'b011011);
        push(4'd12, '0, 0, "R2 row erase");       send_cmd(6'b110001);
        wait_clk(4);
        check(sb_q.size() == 0, "R3 all dataless strobes seen", sb_q.size(), 0);

        // R4: unrecognised code
        stb_before = n_stb;
        send_cmd(6'b000111);
        wait_clk(4);
        check(n_stb == stb_before, "R4 no strobe for unknown code", n_stb, stb_before);
        push(4'd6, '0, 0, "R4 next command aligned"); send_cmd(6'b000110);

        // R5: loads
        push(4'd2, 14'h2A5C, 1, "R5 load program");
        send_cmd(6'b000010); send_load(14'h2A5C);
        push(4'd1, 14'h3FFF, 1, "R5 load config");
        send_cmd(6'b110000); send_load(14'h3FFF);
        // R6: data-memory load keeps low 8 bits
        push(4'd3, 14'h00A7, 1, "R6 load data memory");
        send_cmd(6'b000011); send_load(14'h3EA7);

        // R7: program read
        rd_word = 14'h1234;
        push(4'd4, '0, 0, "R7 read program strobe");
        send_cmd(6'b000100); read_frame(14'h1234, "R7 program");
        // R8: data read, upper slots zero
        rd_word = 14'h3F5A;
        push(4'd5, '0, 0, "R8 read data strobe");
        send_cmd(6'b110101); read_frame(14'h005A, "R8 data");
        // R9: protection, each flag on its own kind
        prot_prog = 1'b1;
        push(4'd4, '0, 0, "R9 protected program strobe");
        send_cmd(6'b000100); read_frame(14'h0000, "R9 program protected");
        push(4'd5, '0, 0, "R9 data unaffected strobe");
        send_cmd(6'b000101); read_frame(14'h005A, "R9 data unaffected by program flag");
        prot_prog = 1'b0;
        prot_data = 1'b1;
        push(4'd5, '0, 0, "R9 protected data strobe");
        send_cmd(6'b000101); read_frame(14'h0000, "R9 data protected");
        rd_word = 14'h2B6D;
        push(4'd4, '0, 0, "R9 program unaffected strobe");
        send_cmd(6'b000100); read_frame(14'h2B6D, "R9 program unaffected by data flag");
        prot_data = 1'b0;

        // R10: enable drop discards partial command
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        link_en = 1'b0;
        wait_clk(6);
        check(sdat_oe == 1'b0, "R10 enable low output off", {31'd0, sdat_oe}, 0);
        link_en = 1'b1;
        wait_clk(4);
        push(4'd12, '0, 0, "R10 realigned after enable drop"); send_cmd(6'b010001);

        // R10: enable drop in a read frame
        push(4'd4, '0, 0, "R10 read before drop");
        send_cmd(6'b000100);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        check(sdat_oe == 1'b1, "R7 driving mid frame", {31'd0, sdat_oe}, 1);
        link_en = 1'b0;
        wait_clk(6);
        check(sdat_oe == 1'b0, "R10 drop releases pin", {31'd0, sdat_oe}, 0);
        link_en = 1'b1;
        wait_clk(4);
        push(4'd9, '0, 0, "R10 command after frame drop"); send_cmd(6'b001010);

        // R11: idle timeout mid-command
        send_bit(1'b1); send_bit(1'b1);
        wait_clk(LIMIT + 50);
        push(4'd2, 14'h0155, 1, "R11 realigned after timeout");
        send_cmd(6'b000010); send_load(14'h0155);

        // R11: timeout mid load frame drops the load
        stb_before = n_stb;
        send_cmd(6'b000010);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        wait_clk(LIMIT + 50);
        check(n_stb == stb_before, "R11 aborted load not strobed", n_stb, stb_before);
        push(4'd11, '0, 0, "R11 command after frame timeout"); send_cmd(6'b001011);

        wait_clk(10);
        check(sb_q.size() == 0, "R12 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule